// File: doc/BRIEF.md
# Unique ID readout register block

This peripheral holds a fixed 128-bit per-device identifier, fixed when the chip is built, and exposes it to software one 32-bit word at a time through a small register window of 1024 bytes. The identifier is set by a parameter at instantiation and is never randomised. Word 0 carries identifier bits [31:0], and each higher word carries the next 32 bits.

To read a word, software writes the control register (offset 0x40). The upper half of the written value is a byte offset into the identifier, and the word index is that offset divided by four. When none of the lock bits is set and the index is in range, the selected word is copied into the key register (offset 0x60). Software then reads the key word from there. Bit 1 of the control value is a write flag and is never stored. Accesses to any other offset, and accesses that are not aligned to 32 bits, are ignored and flagged.

Bus timing is simple. Read data is registered and is valid one cycle after read enable. The error flag pulses in that same cycle.

Top module: `uid_readout`

## Requirements
- R1: After reset, the control register and the key register both read as 0.
- R2: A write to the control register (offset 0x40) stores the write data with bit 1 forced to 0. Reading the control register returns the stored value.
- R3: After a control write whose stored value ANDed with 0xAC is zero, the index is the upper half (bits [31:16]) divided by 4, rounded down. When that index is 0 to 3, the key register (offset 0x60) takes identifier word[index], where word 0 is identifier bits [31:0].
- R4: A control write whose index is 4 or more leaves the key register unchanged.
- R5: A control write with any of bits 2, 3, 5 or 7 set (mask 0xAC) leaves the key register unchanged. The control value is still stored.
- R6: A write to the key register offset changes neither register and raises no error.
- R7: Reads of any aligned offset other than 0x40 and 0x60 return 0, and writes to such offsets are ignored. Each such access pulses the error output for one cycle, in the cycle after the access.
- R8: An access whose address bits [1:0] are not zero is treated as an access to an undefined offset: reads return 0, writes are ignored, and the error output pulses.
- R9: Read data is valid in the cycle after read enable, and is 0 in a cycle that follows no read. A key read issued in the cycle right after a control write returns the newly loaded word.
- R10: When the control register is read and written in the same cycle, the read returns the value held before that write. The new value is visible to the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Byte address within the register window |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | 32 | Registered read data, valid one cycle after read enable |
| busErr | output | 1 | One-cycle pulse after an access to an undefined or unaligned address |

## Verification
A control write and a read can land in the same cycle. Two cases matter: a read of the control register, and a read of the key register in the cycle right after a control write. The bench provokes the first by raising read and write enable together on offset 0x40. It expects the old control value back, and then the new value on the following read. It provokes the second by issuing a key read in the cycle right after each control write. That read must return the freshly selected word, or the previous key when a lock bit or an out-of-range index blocked the load.

// File: rtl/uid_pkg.sv
package uid_pkg;

  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic ctrlWr;   // write hits the control register
    logic keyWr;    // write hits the key register
    logic ctrlRd;   // read hits the control register
    logic keyRd;    // read hits the key register
    logic anyRd;    // any read this cycle
    logic badAcc;   // access to an undefined or unaligned address
  } uidStrobes_t;

endpackage

// File: rtl/uid_ctrl.sv
module uid_ctrl #(
  parameter int ADDR_W   = 10,
  parameter int CTRL_OFF = 'h40,
  parameter int KEY_OFF  = 'h60
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic                 busRe,
  output uid_pkg::uidStrobes_t strobes,
  output logic                 busErr
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_OFF);

  logic aligned;
  logic hitCtrl;
  logic hitKey;
  logic access;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    hitCtrl = aligned && (busAddr == CTRL_A);
    hitKey  = aligned && (busAddr == KEY_A);
    access  = busWe || busRe;

    strobes.ctrlWr = busWe && hitCtrl;
    strobes.keyWr  = busWe && hitKey;
    strobes.ctrlRd = busRe && hitCtrl;
    strobes.keyRd  = busRe && hitKey;
    strobes.anyRd  = busRe;
    strobes.badAcc = access && !(hitCtrl || hitKey);
  end

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= strobes.badAcc;
  end

  // R7
  err_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busWe || busRe));

  // R8
  unaligned_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (access && (busAddr[1:0] != 2'b00)) |=> busErr);

endmodule

// File: rtl/uid_datapath.sv
module uid_datapath #(
  parameter int               DATA_W     = 32,
  parameter int               ID_W       = 128,
  parameter logic [ID_W-1:0]  ID_VALUE   = '0,
  parameter logic [DATA_W-1:0] LOCK_MASK = 'hAC,
  parameter int               FLAG_BIT   = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  uid_pkg::uidStrobes_t strobes,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata
);

  localparam int WORDS = ID_W / DATA_W;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int HALF  = DATA_W / 2;
  localparam int SEL_W = HALF - 2;

  logic [DATA_W-1:0] idWord [WORDS];

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : gWords
      assign idWord[g] = ID_VALUE[g*DATA_W +: DATA_W];
    end
  endgenerate

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] keyReg;
  logic [DATA_W-1:0] ctrlNext;
  logic [SEL_W-1:0]  wordSel;
  logic              unlocked;
  logic              inRange;
  logic [DATA_W-1:0] pickedWord;

  always_comb begin
    ctrlNext           = busWdata;
    ctrlNext[FLAG_BIT] = 1'b0;
    wordSel            = ctrlNext[DATA_W-1:HALF+2];
    unlocked           = ((ctrlNext & LOCK_MASK) == '0);
    inRange            = (int'(wordSel) < WORDS);
    pickedWord         = idWord[wordSel[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      keyReg  <= '0;
    end else if (strobes.ctrlWr) begin
      ctrlReg <= ctrlNext;
      if (unlocked && inRange) keyReg <= pickedWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                busRdata <= '0;
    else if (strobes.ctrlRd)  busRdata <= ctrlReg;
    else if (strobes.keyRd)   busRdata <= keyReg;
    else                      busRdata <= '0;
  end

  // R2
  flag_bit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.ctrlRd) |-> (busRdata[FLAG_BIT] == 1'b0));

  // R4
  range_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ctrlWr && (int'(busWdata[DATA_W-1:HALF]) >= 4*WORDS)) |=> $stable(keyReg));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ctrlWr && ((busWdata & LOCK_MASK) != '0)) |=> $stable(keyReg));

  // R6
  key_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.keyWr && !strobes.ctrlWr) |=> ($stable(keyReg) && $stable(ctrlReg)));

  // R7
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.anyRd && strobes.badAcc) |-> (busRdata == '0));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.anyRd) |-> (busRdata == '0));

endmodule

// File: rtl/uid_readout.sv
module uid_readout #(
  parameter int           ADDR_W   = 10,
  parameter int           DATA_W   = 32,
  parameter int           ID_W     = 128,
  parameter logic [127:0] ID_VALUE = 128'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr
);

  uid_pkg::uidStrobes_t strobes;

  uid_ctrl #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFF('h40),
    .KEY_OFF ('h60)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWe  (busWe),
    .busRe  (busRe),
    .strobes(strobes),
    .busErr (busErr)
  );

  uid_datapath #(
    .DATA_W   (DATA_W),
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE[ID_W-1:0]),
    .LOCK_MASK(DATA_W'('hAC)),
    .FLAG_BIT (1)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busWdata(busWdata),
    .busRdata(busRdata)
  );

endmodule

// File: tb/uid_readout_test.sv
module uid_readout_test;

  localparam logic [127:0] ID = 128'hA5A5_0003_C3C3_0002_5A5A_0001_3C3C_0000;
  localparam logic [31:0] W0 = 32'h3C3C_0000;
  localparam logic [31:0] W1 = 32'h5A5A_0001;
  localparam logic [31:0] W2 = 32'hC3C3_0002;
  localparam logic [31:0] W3 = 32'hA5A5_0003;
  localparam logic [9:0] CTRL = 10'h040;
  localparam logic [9:0] KEY  = 10'h060;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        busErr;

  always #4 clk = ~clk;

  uid_readout #(.ID_VALUE(ID)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata), .busErr(busErr)
  );

  typedef struct {
    bit          chkData;
    logic [31:0] expData;
    logic        expErr;
    string       req;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  // Monitor: results appear after the edge following the access
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.chkData) begin
        nChecks++;
        if (busRdata !== it.expData) begin
          nFails++;
          $display("FAIL %s data: actual %h expected %h", it.req, busRdata, it.expData);
        end
      end
      nChecks++;
      if (busErr !== it.expErr) begin
        nFails++;
        $display("FAIL %s err: actual %b expected %b", it.req, busErr, it.expErr);
      end
    end
  end

  task automatic push(bit cd, logic [31:0] ed, logic ee, string req);
    item_t it;
    it.chkData = cd; it.expData = ed; it.expErr = ee; it.req = req;
    q.push_back(it);
  endtask

  task automatic doWrite(logic [9:0] a, logic [31:0] d, logic ee, string req);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busRe = 1'b0; busWdata = d;
    push(1'b1, 32'h0, ee, req);
  endtask

  task automatic doRead(logic [9:0] a, logic [31:0] ed, logic ee, string req);
    @(negedge clk);
    busAddr = a; busWe = 1'b0; busRe = 1'b1; busWdata = '0;
    push(1'b1, ed, ee, req);
  endtask

  task automatic doBoth(logic [9:0] a, logic [31:0] d, logic [31:0] ed, string req);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busRe = 1'b1; busWdata = d;
    push(1'b1, ed, 1'b0, req);
  endtask

  task automatic doIdle(string req);
    @(negedge clk);
    busAddr = '0; busWe = 1'b0; busRe = 1'b0; busWdata = '0;
    push(1'b1, 32'h0, 1'b0, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] words [4];
    words[0] = W0; words[1] = W1; words[2] = W2; words[3] = W3;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    doRead(CTRL, 32'h0, 1'b0, "R1");
    doRead(KEY,  32'h0, 1'b0, "R1");

    // R3 all four words, R9 key read right after the write, R2 readback
    for (int i = 0; i < 4; i++) begin
      doWrite(CTRL, 32'(i * 4) << 16, 1'b0, "R3");
      doRead(KEY, words[i], 1'b0, "R3_R9");
      doRead(CTRL, 32'(i * 4) << 16, 1'b0, "R2");
    end

    // R3 byte offset 6 rounds down to word 1
    doWrite(CTRL, 32'h0006_0000, 1'b0, "R3");
    doRead(KEY, W1, 1'b0, "R3");

    // R4 out-of-range indices
    doWrite(CTRL, 32'h0000_0000, 1'b0, "R4");
    doWrite(CTRL, 32'h0010_0000, 1'b0, "R4");
    doRead(KEY, W0, 1'b0, "R4");
    doWrite(CTRL, 32'hFFFF_0000, 1'b0, "R4");
    doRead(KEY, W0, 1'b0, "R4");
    doRead(CTRL, 32'hFFFF_0000, 1'b0, "R4");

    // R5 each lock bit blocks the load
    doWrite(CTRL, 32'h0008_0000, 1'b0, "R5");
    foreach (words[k]) if (k == 0) ; // no-op to keep structure simple
    for (int b = 0; b < 8; b++) begin
      if (b == 2 || b == 3 || b == 5 || b == 7) begin
        doWrite(CTRL, 32'h0000_0000 | (32'h1 << b), 1'b0, "R5");
        doRead(KEY, W2, 1'b0, "R5");
        doRead(CTRL, 32'h1 << b, 1'b0, "R5");
      end
    end

    // R2 flag bit never stored
    doWrite(CTRL, 32'hFFFF_FFFF, 1'b0, "R2");
    doRead(CTRL, 32'hFFFF_FFFD, 1'b0, "R2");
    doRead(KEY, W2, 1'b0, "R2");
    doWrite(CTRL, 32'h0000_0002, 1'b0, "R2");
    doRead(CTRL, 32'h0, 1'b0, "R2");
    doRead(KEY, W0, 1'b0, "R2");

    // R6 key writes ignored
    doWrite(CTRL, 32'h000C_0000, 1'b0, "R6");
    doWrite(KEY, 32'h1234_5678, 1'b0, "R6");
    doRead(KEY, W3, 1'b0, "R6");
    doRead(CTRL, 32'h000C_0000, 1'b0, "R6");

    // R7 undefined offsets
    doRead(10'h000, 32'h0, 1'b1, "R7");
    doRead(10'h3FC, 32'h0, 1'b1, "R7");
    doWrite(10'h100, 32'h0004_0000, 1'b1, "R7");
    doWrite(10'h044, 32'h0004_0000, 1'b1, "R7");
    doRead(CTRL, 32'h000C_0000, 1'b0, "R7");
    doRead(KEY, W3, 1'b0, "R7");

    // R8 unaligned accesses
    doWrite(10'h041, 32'h0004_0000, 1'b1, "R8");
    doRead(CTRL, 32'h000C_0000, 1'b0, "R8");
    doRead(10'h062, 32'h0, 1'b1, "R8");
    doRead(10'h043, 32'h0, 1'b1, "R8");

    // R9 no read gives zero data
    doIdle("R9");

    // R10 simultaneous read and write of control
    doBoth(CTRL, 32'h0004_0000, 32'h000C_0000, "R10");
    doRead(CTRL, 32'h0004_0000, 1'b0, "R10");
    doRead(KEY, W1, 1'b0, "R10");

    doIdle("R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule